// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received frames from a byte stream and lays each one into the buffer of the next free slot in a receive ring. When the last byte of a frame has been stored, it writes a status word into that slot's descriptor. The word holds the stored length, start and end markers, and a truncation flag. It then advances a 16-bit producer index. Software reads the producer index and handles the frames. It hands buffers back by writing a 16-bit consumer index. Occupancy is the difference of the two indices, taken modulo 65536.

An option places two zero bytes ahead of each frame, so that the payload that follows the 14-byte Ethernet header lands on a word boundary. These two bytes count in the reported length. A frame that is longer than the configured buffer size is cut off at that size. A frame that arrives when every slot is occupied is swallowed whole and counted. A flow-control output with hysteresis, `xoff`, is driven from the number of free slots.

Back-pressure works as follows. A byte moves on the input stream only in a cycle where `in_valid` and `in_ready` are both high. `in_valid` must then stay high until the byte is taken. The memory write master moves one beat in each cycle where `mw_valid` and `mw_ready` are both high. While a frame's bytes are being stored, `in_ready` follows `mw_ready`.

Top module: `rx_ring_writer`

## Requirements
- R1: After reset the register reads are as follows: producer 0, consumer 0, drop count 0, align option off, ring size RING_MAX, buffer size BUF_MAX. The flow word holds XOFF_DEF in bits 15:0 and GAP_DEF in bits 31:16. `xoff` is low and `in_ready` is low.
- R2: `in_ready` is low while the block waits for a frame to start and while it writes the two pad bytes. An input byte is taken only when `in_valid` and `in_ready` are both high.
- R3: With the align option off, frame byte k is written to byte address slot*BUF_MAX + k (`mw_desc` low, byte in `mw_data[7:0]`), in arrival order. BUF_MAX is a power of two.
- R4: With the align option on (register 0 bit 0 = 1), zero bytes are written at offsets 0 and 1. Frame byte k goes to offset k+2, and the recorded length includes the two pad bytes.
- R5: After the data, one descriptor write is made with `mw_desc` high and `mw_addr` equal to the slot number. Its word holds the stored length in bits 27:16, bit 14 = 1 (end of frame), bit 13 = 1 (start of frame), bit 15 = 0 (ownership returned) and bit 1 = truncation flag. All other bits are 0. The word is held stable until it is accepted.
- R6: Each accepted descriptor write raises the producer index by exactly one, modulo 65536. The slot number then moves to the next slot, and goes to 0 after slot ring_size-1. ring_size is set through register 3.
- R7: Software writes the consumer index through register 1 and can read it back. Occupancy = producer - consumer (mod 65536), and the ring is empty when the two are equal.
- R8: When a frame starts with occupancy >= ring_size, all of its bytes are accepted but nothing is written to memory. The producer stays unchanged and the drop count (register 6) rises by one.
- R9: Frame bytes beyond the buffer size (register 4) are still accepted but are not written. The recorded length is then the buffer size and bit 1 is set. A frame that exactly fills the buffer leaves bit 1 clear.
- R10: `xoff` goes high one cycle after free slots (ring_size - occupancy) fall to or below the high mark, which is register 5 bits 15:0.
- R11: `xoff` goes low one cycle after free slots exceed the high mark plus the gap, which is register 5 bits 31:16. In between, `xoff` keeps its value.
- R12: The registers sit at `reg_addr` 0 to 6: control, consumer, producer (read only), ring size, buffer size, flow word, drop count (read only). Writes take effect on `reg_wr`, and `reg_rdata` shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input byte present |
| in_ready | output | 1 | Input byte taken this cycle |
| in_last | input | 1 | Byte ends the frame |
| in_data | input | 8 | Frame byte |
| mw_valid | output | 1 | Write beat present |
| mw_ready | input | 1 | Memory takes the beat |
| mw_desc | output | 1 | 1: descriptor word, 0: buffer byte |
| mw_addr | output | AW (19) | Byte address, or slot number when mw_desc is high |
| mw_data | output | 32 | Descriptor word, or byte in bits 7:0 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Addressed register value |
| xoff | output | 1 | Flow-control pause request |

## Verification
The bench sweeps frame lengths from one byte to past the buffer size, once with the align option off and once with it on. This separates the plain and padded byte offsets, and shows whether the truncation flag changes exactly at the boundary where a frame fills the buffer. It stalls the memory side on a fixed pattern and leaves gaps in the input stream, which tests that the data path honours back-pressure. It fills the ring without consuming and then frees it one slot at a time. This walks free slots through the set region, the hold region and the release region of the flow control, and makes the ring full so that a dropped frame can be told apart from a stored one. A ring size that is not a power of two checks that the slot number wraps at the programmed size.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int LEN_LSB = 16;
  localparam int LEN_W   = 12;
  localparam int OWN_BIT = 15;
  localparam int EOP_BIT = 14;
  localparam int SOP_BIT = 13;
  localparam int OVF_BIT = 1;
  localparam int IDX_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PAD, ST_DATA, ST_DESC, ST_DROP
  } wr_state_e;

  localparam logic [2:0] RA_CTL  = 3'd0;
  localparam logic [2:0] RA_CONS = 3'd1;
  localparam logic [2:0] RA_PROD = 3'd2;
  localparam logic [2:0] RA_RING = 3'd3;
  localparam logic [2:0] RA_BUF  = 3'd4;
  localparam logic [2:0] RA_FLOW = 3'd5;
  localparam logic [2:0] RA_DROP = 3'd6;
endpackage

// File: rtl/rxr_regs.sv
module rxr_regs
  import rxr_pkg::*;
#(
  parameter int RING_MAX = 256,
  parameter int BUF_MAX  = 2048,
  parameter int XOFF_DEF = 16,
  parameter int GAP_DEF  = 5,
  localparam int RS_W = $clog2(RING_MAX) + 1,
  localparam int BS_W = $clog2(BUF_MAX) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [31:0]      reg_wdata,
  input  logic [IDX_W-1:0] prod_idx,
  input  logic [15:0]      drop_cnt,
  output logic             align_en,
  output logic [IDX_W-1:0] cons_idx,
  output logic [RS_W-1:0]  ring_sz,
  output logic [BS_W-1:0]  buf_sz,
  output logic [15:0]      xoff_thr,
  output logic [15:0]      xon_gap,
  output logic [31:0]      reg_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      align_en <= 1'b0;
      cons_idx <= '0;
      ring_sz  <= RS_W'(RING_MAX);
      buf_sz   <= BS_W'(BUF_MAX);
      xoff_thr <= 16'(XOFF_DEF);
      xon_gap  <= 16'(GAP_DEF);
    end else if (reg_wr) begin
      case (reg_addr)
        RA_CTL:  align_en <= reg_wdata[0];
        RA_CONS: cons_idx <= reg_wdata[IDX_W-1:0];
        RA_RING: ring_sz  <= reg_wdata[RS_W-1:0];
        RA_BUF:  buf_sz   <= reg_wdata[BS_W-1:0];
        RA_FLOW: begin
          xoff_thr <= reg_wdata[15:0];
          xon_gap  <= reg_wdata[31:16];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_addr)
      RA_CTL:  reg_rdata = {31'd0, align_en};
      RA_CONS: reg_rdata = 32'(cons_idx);
      RA_PROD: reg_rdata = 32'(prod_idx);
      RA_RING: reg_rdata = 32'(ring_sz);
      RA_BUF:  reg_rdata = 32'(buf_sz);
      RA_FLOW: reg_rdata = {xon_gap, xoff_thr};
      RA_DROP: reg_rdata = 32'(drop_cnt);
      default: reg_rdata = 32'd0;
    endcase
  end
endmodule

// File: rtl/rxr_index.sv
module rxr_index
  import rxr_pkg::*;
#(
  parameter int RING_MAX = 256,
  localparam int RS_W   = $clog2(RING_MAX) + 1,
  localparam int SLOT_W = $clog2(RING_MAX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  logic [RS_W-1:0]   ring_sz,
  input  logic [IDX_W-1:0]  cons_idx,
  output logic [IDX_W-1:0]  prod_idx,
  output logic [SLOT_W-1:0] slot,
  output logic              full,
  output logic [IDX_W-1:0]  free_cnt
);
  logic [IDX_W-1:0] occ;
  logic [IDX_W-1:0] ring_ext;
  logic             slot_last;

  assign occ       = prod_idx - cons_idx;
  assign ring_ext  = IDX_W'(ring_sz);
  assign full      = (occ >= ring_ext);
  assign free_cnt  = full ? '0 : (ring_ext - occ);
  assign slot_last = (RS_W'(slot) + RS_W'(1)) >= ring_sz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_idx <= '0;
      slot     <= '0;
    end else if (frame_done) begin
      prod_idx <= prod_idx + 1'b1;
      slot     <= slot_last ? '0 : slot + 1'b1;
    end
  end

  // R6
  prod_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (prod_idx == $past(prod_idx)) || (prod_idx == $past(prod_idx) + 16'd1));

  // R6
  slot_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prod_idx != $past(prod_idx)) |-> ((slot != $past(slot)) || ($past(ring_sz) <= 1)));
endmodule

// File: rtl/rxr_flow.sv
module rxr_flow
  import rxr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] free_cnt,
  input  logic [15:0]      xoff_thr,
  input  logic [15:0]      xon_gap,
  output logic             xoff
);
  logic [16:0] release_lvl;
  assign release_lvl = {1'b0, xoff_thr} + {1'b0, xon_gap};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              xoff <= 1'b0;
    else if (free_cnt <= xoff_thr)           xoff <= 1'b1;
    else if ({1'b0, free_cnt} > release_lvl) xoff <= 1'b0;
  end

  // R10
  xoff_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff) |-> ($past(free_cnt) <= $past(xoff_thr)));

  // R11
  xoff_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(xoff) |-> ({1'b0, $past(free_cnt)} > ({1'b0, $past(xoff_thr)} + {1'b0, $past(xon_gap)})));
endmodule

// File: rtl/rxr_frame.sv
module rxr_frame
  import rxr_pkg::*;
#(
  parameter int RING_MAX = 256,
  parameter int BUF_MAX  = 2048,
  localparam int SLOT_W = $clog2(RING_MAX),
  localparam int OFF_W  = $clog2(BUF_MAX),
  localparam int BS_W   = OFF_W + 1,
  localparam int AW     = SLOT_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_last,
  input  logic [7:0]        in_data,
  input  logic              align_en,
  input  logic [BS_W-1:0]   buf_sz,
  input  logic              full,
  input  logic [SLOT_W-1:0] slot,
  output logic              mw_valid,
  input  logic              mw_ready,
  output logic              mw_desc,
  output logic [AW-1:0]     mw_addr,
  output logic [31:0]       mw_data,
  output logic              frame_done,
  output logic [15:0]       drop_cnt
);
  wr_state_e       state;
  logic [BS_W-1:0] cnt;
  logic            ovf;
  logic            fits;
  logic            take;
  logic [31:0]     desc_word;

  assign fits = (cnt < buf_sz);
  assign take = in_valid && in_ready;
  assign desc_word = (32'(cnt) << LEN_LSB) | (32'd1 << EOP_BIT) |
                     (32'd1 << SOP_BIT) | (32'(ovf) << OVF_BIT);

  always_comb begin
    in_ready = 1'b0;
    mw_valid = 1'b0;
    mw_desc  = 1'b0;
    mw_addr  = {slot, cnt[OFF_W-1:0]};
    mw_data  = 32'd0;
    case (state)
      ST_PAD:  mw_valid = 1'b1;
      ST_DATA: begin
        mw_valid = in_valid && fits;
        mw_data  = {24'd0, in_data};
        in_ready = fits ? mw_ready : 1'b1;
      end
      ST_DESC: begin
        mw_valid = 1'b1;
        mw_desc  = 1'b1;
        mw_addr  = AW'(slot);
        mw_data  = desc_word;
      end
      ST_DROP: in_ready = 1'b1;
      default: ;
    endcase
  end

  assign frame_done = (state == ST_DESC) && mw_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      ovf      <= 1'b0;
      drop_cnt <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid) begin
          cnt <= '0;
          ovf <= 1'b0;
          if (full)          state <= ST_DROP;
          else if (align_en) state <= ST_PAD;
          else               state <= ST_DATA;
        end
        ST_PAD: if (mw_ready) begin
          cnt <= cnt + 1'b1;
          if (cnt[0]) state <= ST_DATA;
        end
        ST_DATA: if (take) begin
          if (fits) cnt <= cnt + 1'b1;
          else      ovf <= 1'b1;
          if (in_last) state <= ST_DESC;
        end
        ST_DESC: if (mw_ready) state <= ST_IDLE;
        ST_DROP: if (take && in_last) begin
          drop_cnt <= drop_cnt + 1'b1;
          state    <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R5
  desc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mw_valid && mw_desc && !mw_ready) |=>
      (mw_valid && mw_desc && $stable(mw_addr) && $stable(mw_data)));

  // R2
  pad_no_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_PAD) |-> !in_ready);
endmodule

// File: rtl/rx_ring_writer.sv
module rx_ring_writer
  import rxr_pkg::*;
#(
  parameter int RING_MAX = 256,
  parameter int BUF_MAX  = 2048,
  parameter int XOFF_DEF = 16,
  parameter int GAP_DEF  = 5,
  localparam int SLOT_W = $clog2(RING_MAX),
  localparam int OFF_W  = $clog2(BUF_MAX),
  localparam int RS_W   = SLOT_W + 1,
  localparam int BS_W   = OFF_W + 1,
  localparam int AW     = SLOT_W + OFF_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_last,
  input  logic [7:0]    in_data,
  output logic          mw_valid,
  input  logic          mw_ready,
  output logic          mw_desc,
  output logic [AW-1:0] mw_addr,
  output logic [31:0]   mw_data,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          xoff
);
  logic              align_en, full, frame_done;
  logic [IDX_W-1:0]  cons_idx, prod_idx, free_cnt;
  logic [RS_W-1:0]   ring_sz;
  logic [BS_W-1:0]   buf_sz;
  logic [15:0]       xoff_thr, xon_gap, drop_cnt;
  logic [SLOT_W-1:0] slot;

  rxr_regs #(.RING_MAX(RING_MAX), .BUF_MAX(BUF_MAX), .XOFF_DEF(XOFF_DEF), .GAP_DEF(GAP_DEF)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .prod_idx(prod_idx), .drop_cnt(drop_cnt), .align_en(align_en), .cons_idx(cons_idx),
    .ring_sz(ring_sz), .buf_sz(buf_sz), .xoff_thr(xoff_thr), .xon_gap(xon_gap),
    .reg_rdata(reg_rdata));

  rxr_index #(.RING_MAX(RING_MAX)) u_index (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .ring_sz(ring_sz),
    .cons_idx(cons_idx), .prod_idx(prod_idx), .slot(slot), .full(full),
    .free_cnt(free_cnt));

  rxr_flow u_flow (
    .clk(clk), .rst_n(rst_n), .free_cnt(free_cnt), .xoff_thr(xoff_thr),
    .xon_gap(xon_gap), .xoff(xoff));

  rxr_frame #(.RING_MAX(RING_MAX), .BUF_MAX(BUF_MAX)) u_frame (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_data(in_data), .align_en(align_en), .buf_sz(buf_sz),
    .full(full), .slot(slot), .mw_valid(mw_valid), .mw_ready(mw_ready),
    .mw_desc(mw_desc), .mw_addr(mw_addr), .mw_data(mw_data),
    .frame_done(frame_done), .drop_cnt(drop_cnt));

  // R8
  drop_keeps_prod_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_cnt != $past(drop_cnt)) |-> (prod_idx == $past(prod_idx)));
endmodule

// File: tb/tb_rx_ring_writer.sv
module tb_rx_ring_writer;
  localparam int RM = 8;
  localparam int BM = 16;
  localparam int XH = 2;
  localparam int XG = 3;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0;
  logic [7:0] in_data = 8'd0;
  logic in_ready;
  logic mw_valid, mw_desc;
  logic mw_ready = 1'b1;
  logic [AW-1:0] mw_addr;
  logic [31:0] mw_data;
  logic reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic xoff;

  int total = 0, bad = 0, cyc = 0, wr_count = 0;
  bit stall_on = 1'b1;
  logic [7:0]  mem [RM*BM];
  logic [31:0] desc [RM];
  int exp_slot = 0, ring = RM, exp_prod = 0;
  bit xmodel = 1'b0;

  always #5 clk = ~clk;

  rx_ring_writer #(.RING_MAX(RM), .BUF_MAX(BM), .XOFF_DEF(XH), .GAP_DEF(XG)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_last(in_last), .in_data(in_data), .mw_valid(mw_valid), .mw_ready(mw_ready),
    .mw_desc(mw_desc), .mw_addr(mw_addr), .mw_data(mw_data), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xoff(xoff));

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mw_valid && mw_ready) begin
      wr_count <= wr_count + 1;
      if (mw_desc) desc[int'(mw_addr[2:0])] <= mw_data;
      else         mem[int'(mw_addr)] <= mw_data[7:0];
    end
  end

  always @(negedge clk) mw_ready <= stall_on ? ((cyc % 3) != 0) : 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic send_frame(input int len, input logic [7:0] seed);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1; in_data = seed + 8'(i); in_last = (i == len - 1);
      #1;
      while (!in_ready) begin @(negedge clk); #1; end
      @(posedge clk); @(negedge clk);
      in_valid = 1'b0; in_last = 1'b0;
      if (i % 4 == 3) @(negedge clk);
    end
  endtask

  task automatic wait_prod(input int exp);
    logic [31:0] v;
    reg_read(3'd2, v);
    while (v != 32'(exp & 16'hffff)) begin @(negedge clk); reg_read(3'd2, v); end
  endtask

  task automatic slot_step();
    exp_slot = (exp_slot >= ring - 1) ? 0 : exp_slot + 1;
    exp_prod++;
  endtask

  task automatic check_frame(input int slot, input int len, input bit al,
                             input logic [7:0] seed, input int bsz);
    int pad, stored, mism;
    bit ov;
    logic [31:0] w;
    pad = al ? 2 : 0;
    stored = (len + pad > bsz) ? bsz : len + pad;
    ov = (len + pad > bsz);
    w = (32'(stored) << 16) | (32'd1 << 14) | (32'd1 << 13) | (32'(ov) << 1);
    chk(ov ? "R9 desc word (truncated)" : "R5 desc word", desc[slot], w);
    mism = 0;
    for (int k = 0; k < stored; k++) begin
      logic [7:0] e;
      e = (k < pad) ? 8'd0 : seed + 8'(k - pad);
      if (mem[slot*BM + k] !== e) mism++;
    end
    chk(al ? "R4 padded contents" : "R3 plain contents", 32'(mism), 32'd0);
  endtask

  function automatic bit flow_next(input bit cur, input int occ);
    int fr;
    fr = (occ >= ring) ? 0 : ring - occ;
    if (fr <= XH) return 1'b1;
    if (fr > XH + XG) return 1'b0;
    return cur;
  endfunction

  initial begin
    repeat (400000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R6 act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int dc, wc0, cons;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R12 reset register values
    reg_read(3'd0, v); chk("R1 ctl", v, 32'd0);
    reg_read(3'd1, v); chk("R1 cons", v, 32'd0);
    reg_read(3'd2, v); chk("R1 prod", v, 32'd0);
    reg_read(3'd3, v); chk("R1 ring", v, 32'(RM));
    reg_read(3'd4, v); chk("R1 buf", v, 32'(BM));
    reg_read(3'd5, v); chk("R1 flow", v, (32'(XG) << 16) | 32'(XH));
    reg_read(3'd6, v); chk("R1 drop", v, 32'd0);
    chk("R1 xoff", 32'(xoff), 32'd0);
    chk("R1 in_ready", 32'(in_ready), 32'd0);

    // R2: ready low in idle and pad phases
    reg_write(3'd0, 32'd1);
    in_valid = 1'b1; in_data = 8'h40; in_last = 1'b0;
    #1; chk("R2 ready low idle", 32'(in_ready), 32'd0);
    @(negedge clk); #1; chk("R2 ready low pad", 32'(in_ready), 32'd0);
    send_frame(5, 8'h40);
    wait_prod(exp_prod + 1);
    check_frame(exp_slot, 5, 1'b1, 8'h40, BM);
    slot_step();
    reg_write(3'd1, 32'(exp_prod));

    // Sweep lengths, align off then on (R3 R4 R5 R6 R9)
    for (int al = 0; al < 2; al++) begin
      reg_write(3'd0, 32'(al));
      for (int len = 1; len <= BM + 3; len++) begin
        logic [7:0] seed;
        seed = 8'(len * 7 + al * 50);
        send_frame(len, seed);
        wait_prod(exp_prod + 1);
        check_frame(exp_slot, len, al[0], seed, BM);
        slot_step();
        reg_read(3'd2, v); chk("R6 producer step", v, 32'(exp_prod));
        reg_write(3'd1, 32'(exp_prod));
      end
    end

    // R7: consumer readback
    reg_read(3'd1, v); chk("R7 consumer readback", v, 32'(exp_prod));

    // Buffer size register (R9, R12)
    reg_write(3'd0, 32'd0);
    reg_write(3'd4, 32'd8);
    send_frame(10, 8'h90);
    wait_prod(exp_prod + 1);
    check_frame(exp_slot, 10, 1'b0, 8'h90, 8);
    slot_step();
    send_frame(8, 8'hA0);
    wait_prod(exp_prod + 1);
    check_frame(exp_slot, 8, 1'b0, 8'hA0, 8);
    slot_step();
    reg_write(3'd1, 32'(exp_prod));
    reg_write(3'd4, 32'(BM));

    // Fill without consuming (R10), then drop (R8)
    stall_on = 1'b0;
    cons = exp_prod;
    xmodel = 1'b0;
    for (int n = 1; n <= RM; n++) begin
      send_frame(3, 8'(n));
      wait_prod(exp_prod + 1);
      check_frame(exp_slot, 3, 1'b0, 8'(n), BM);
      slot_step();
      @(negedge clk); @(negedge clk);
      xmodel = flow_next(xmodel, n);
      chk("R10 xoff while filling", 32'(xoff), 32'(xmodel));
    end
    reg_read(3'd6, v); dc = int'(v);
    wc0 = wr_count;
    send_frame(4, 8'h77);
    @(negedge clk);
    reg_read(3'd6, v); chk("R8 drop count", v, 32'(dc + 1));
    reg_read(3'd2, v); chk("R8 producer held", v, 32'(exp_prod));
    chk("R8 no memory writes", 32'(wr_count - wc0), 32'd0);

    // Release one slot at a time (R11)
    for (int n = 1; n <= RM; n++) begin
      reg_write(3'd1, 32'(cons + n));
      @(negedge clk); @(negedge clk);
      xmodel = flow_next(xmodel, RM - n);
      chk("R11 xoff while draining", 32'(xoff), 32'(xmodel));
    end

    // Ring size 5 (R6 wrap)
    stall_on = 1'b1;
    reg_write(3'd3, 32'd5);
    ring = 5;
    if (exp_slot >= ring) exp_slot = 0;
    for (int n = 0; n < 7; n++) begin
      send_frame(3, 8'(8'hC0 + n));
      wait_prod(exp_prod + 1);
      check_frame(exp_slot, 3, 1'b0, 8'(8'hC0 + n), BM);
      slot_step();
      reg_write(3'd1, 32'(exp_prod));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule